// File: doc/BRIEF.md
# Paged DMA Address Generator

This block forms the memory address for one DMA channel. The address joins a page value and an offset counter. The page register is written once per transfer and never counts. The offset counter advances by one count for each step pulse from the transfer sequencer. When the counter rolls over, it stays inside the current window and never carries into the page bits.

Two transfer widths are supported. In byte mode the address is the page above the offset, and each step advances it by one. In word mode the counter sits one bit higher, so address bit 0 is always zero and each step advances the address by two. The window becomes twice as large, and only the lower page bits reach the address; the top page bit is discarded.

The width is captured together with the page and the start offset on a load strobe. A size output reports that captured width beside the address. Decoding of host registers and counting of the transfer length are outside this block.

Top module: `dma_page_addr_gen`

## Requirements
- R1: Reset behaviour. While `rst` is high and on the clock edge after it, `addr_o` is all zeros and `word_size_o` is 0.
- R2: Load latency. When `load_i` is high on a clock edge, the page (`page_i`), start offset (`offset_i`) and width (`word_mode_i`) are captured. On the second edge after that, `addr_o` and `word_size_o` reflect the captured values.
- R3: Byte step. In byte mode (`word_size_o` = 0), `addr_o` equals `{page, offset}`. Each step pulse raises the offset field (the low OFS_W bits) by exactly 1, and the output follows two edges later.
- R4: Byte wrap. In byte mode, stepping from an all-ones offset yields an all-zero offset. The page field of `addr_o` is unchanged, and no error is raised.
- R5: Word form. In word mode (`word_size_o` = 1), `addr_o` equals `{page[PAGE_W-2:0], offset, 1'b0}`. Address bit 0 is always 0, and the top page bit does not appear in the address.
- R6: Word step and wrap. In word mode, each step raises the low OFS_W+1 address bits by 2. Stepping from the last word of a window returns to the first word of the same window.
- R7: Page hold. Step pulses never change the page bits of `addr_o`; only a load does.
- R8: Load priority. If `load_i` and `step_i` are high on the same edge, the loaded offset is used as it stands and the step is discarded.
- R9: Width capture. `word_mode_i` has an effect only on a load edge. A change of `word_mode_i` without a load leaves `addr_o` and `word_size_o` unchanged.
- R10: Hold. With neither load nor step, `addr_o` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Capture page, start offset and width |
| page_i | input | PAGE_W (8) | Page value to load |
| offset_i | input | OFS_W (16) | Start offset to load |
| word_mode_i | input | 1 | Width to load: 0 byte, 1 word |
| step_i | input | 1 | Advance offset by one count |
| addr_o | output | PAGE_W+OFS_W (24) | Registered memory address |
| word_size_o | output | 1 | Registered width: 0 = 8-bit unit, 1 = 16-bit unit |

## Verification
The properties assume that `load_i` and `step_i` hold known values in every cycle, including during reset. A step or load seen in the three cycles before a check is treated as part of that check's history. Under this assumption, the pipeline relations between two consecutive address samples can be stated without a reference model. The stimulus changes every input only on the falling clock edge and holds all strobes at zero while reset is high. Steps are applied either as single pulses or as one long continuous run after a load. As a result, every sample the properties compare comes from a clean load or a clean run of steps.

// File: rtl/dpag_pkg.sv
package dpag_pkg;

  typedef enum logic {
    XW_BYTE = 1'b0,
    XW_WORD = 1'b1
  } xfer_width_e;

endpackage

// File: rtl/dpag_page_reg.sv
module dpag_page_reg
  import dpag_pkg::*;
#(
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic              word_mode_i,
  output logic [PAGE_W-1:0] page_o,
  output xfer_width_e       width_o
);

  // page and width change only on load; stepping never reaches here
  always_ff @(posedge clk) begin
    if (rst) begin
      page_o  <= '0;
      width_o <= XW_BYTE;
    end else if (load_i) begin
      page_o  <= page_i;
      width_o <= word_mode_i ? XW_WORD : XW_BYTE;
    end
  end

endmodule

// File: rtl/dpag_offset_ctr.sv
module dpag_offset_ctr #(
  parameter int OFS_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [OFS_W-1:0] offset_i,
  input  logic             step_i,
  output logic [OFS_W-1:0] count_o
);

  localparam logic [OFS_W-1:0] ONE = OFS_W'(1);

  // load wins over step; the add is modulo 2**OFS_W, so it wraps in-window
  always_ff @(posedge clk) begin
    if (rst) begin
      count_o <= '0;
    end else if (load_i) begin
      count_o <= offset_i;
    end else if (step_i) begin
      count_o <= count_o + ONE;
    end
  end

endmodule

// File: rtl/dpag_addr_form.sv
module dpag_addr_form
  import dpag_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int OFS_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [PAGE_W-1:0]       page_i,
  input  logic [OFS_W-1:0]        count_i,
  input  xfer_width_e             width_i,
  output logic [PAGE_W+OFS_W-1:0] addr_o,
  output logic                    word_size_o
);

  localparam int ADDR_W = PAGE_W + OFS_W;

  logic [ADDR_W-1:0] byte_addr;
  logic [ADDR_W-1:0] word_addr;
  logic [ADDR_W-1:0] addr_d;

  assign byte_addr = {page_i, count_i};

  generate
    if (PAGE_W >= 2) begin : g_word_wide_page
      assign word_addr = {page_i[PAGE_W-2:0], count_i, 1'b0};
    end else begin : g_word_no_page
      assign word_addr = {count_i, 1'b0};
    end
  endgenerate

  assign addr_d = (width_i == XW_WORD) ? word_addr : byte_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_o      <= '0;
      word_size_o <= 1'b0;
    end else begin
      addr_o      <= addr_d;
      word_size_o <= (width_i == XW_WORD);
    end
  end

endmodule

// File: rtl/dma_page_addr_gen.sv
module dma_page_addr_gen
  import dpag_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int OFS_W  = 16,
  localparam int ADDR_W = PAGE_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [OFS_W-1:0]  offset_i,
  input  logic              word_mode_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              word_size_o
);

  logic [PAGE_W-1:0] page_q;
  logic [OFS_W-1:0]  count_q;
  xfer_width_e       width_q;

  dpag_page_reg #(.PAGE_W(PAGE_W)) u_page (
    .clk         (clk),
    .rst         (rst),
    .load_i      (load_i),
    .page_i      (page_i),
    .word_mode_i (word_mode_i),
    .page_o      (page_q),
    .width_o     (width_q)
  );

  dpag_offset_ctr #(.OFS_W(OFS_W)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .load_i   (load_i),
    .offset_i (offset_i),
    .step_i   (step_i),
    .count_o  (count_q)
  );

  dpag_addr_form #(.PAGE_W(PAGE_W), .OFS_W(OFS_W)) u_form (
    .clk         (clk),
    .rst         (rst),
    .page_i      (page_q),
    .count_i     (count_q),
    .width_i     (width_q),
    .addr_o      (addr_o),
    .word_size_o (word_size_o)
  );

endmodule

// File: rtl/dpag_checker.sv
module dpag_checker #(
  parameter int PAGE_W = 8,
  parameter int OFS_W  = 16,
  localparam int ADDR_W = PAGE_W + OFS_W
) (
  input logic              clk,
  input logic              rst,
  input logic              load_i,
  input logic              step_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              word_size_o
);

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (addr_o == '0 && !word_size_o));

  a_r5_word_bit0_low: assert property (@(posedge clk) disable iff (rst)
    word_size_o |-> !addr_o[0]);

  a_r3_byte_step_one: assert property (@(posedge clk) disable iff (rst)
    (!word_size_o && $past(step_i, 2) && !$past(load_i, 2))
    |-> (addr_o[OFS_W-1:0] == $past(addr_o[OFS_W-1:0]) + OFS_W'(1)));

  a_r6_word_step_two: assert property (@(posedge clk) disable iff (rst)
    (word_size_o && $past(step_i, 2) && !$past(load_i, 2))
    |-> (addr_o[OFS_W:0] == $past(addr_o[OFS_W:0]) + (OFS_W+1)'(2)));

  a_r7_page_steady: assert property (@(posedge clk) disable iff (rst)
    (!$past(load_i) && !$past(load_i, 2) && $stable(word_size_o))
    |-> $stable(addr_o[ADDR_W-1:OFS_W+1]));

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(step_i, 2) && !$past(load_i, 2)) |-> $stable(addr_o));

endmodule

bind dma_page_addr_gen dpag_checker #(.PAGE_W(PAGE_W), .OFS_W(OFS_W)) u_dpag_chk (
  .clk         (clk),
  .rst         (rst),
  .load_i      (load_i),
  .step_i      (step_i),
  .addr_o      (addr_o),
  .word_size_o (word_size_o)
);

// File: tb/test_dma_page_addr_gen.sv
module test_dma_page_addr_gen;

  localparam int CLK_PERIOD = 10;
  localparam int PW = 4;
  localparam int OW = 8;
  localparam int AW = PW + OW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          load_i = 1'b0;
  logic [PW-1:0] page_i = '0;
  logic [OW-1:0] offset_i = '0;
  logic          word_mode_i = 1'b0;
  logic          step_i = 1'b0;
  logic [AW-1:0] addr_o;
  logic          word_size_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_page_addr_gen #(.PAGE_W(PW), .OFS_W(OW)) i_dma_page_addr_gen (
    .clk (clk), .rst (rst), .load_i (load_i), .page_i (page_i),
    .offset_i (offset_i), .word_mode_i (word_mode_i), .step_i (step_i),
    .addr_o (addr_o), .word_size_o (word_size_o)
  );

  function automatic logic [AW-1:0] expect_addr(input int pg, input int ofs, input bit wm);
    int o;
    o = ofs % (1 << OW);
    if (wm) return AW'(((pg % (1 << (PW-1))) << (OW+1)) + (o << 1));
    return AW'((pg << OW) + o);
  endfunction

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_load(input int pg, input int ofs, input bit wm);
    page_i = PW'(pg); offset_i = OW'(ofs); word_mode_i = wm; load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
    @(negedge clk);
  endtask

  // continuous run of n steps, checking every cycle
  task automatic run_steps(input int pg, input int ofs, input bit wm, input int n, input string req);
    step_i = 1'b1;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      chk(req, addr_o, expect_addr(pg, ofs + k - 1, wm));
      if (k == n) step_i = 1'b0;
    end
    @(negedge clk);
    chk(req, addr_o, expect_addr(pg, ofs + n, wm));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 addr in reset", addr_o, '0);
    chk("R1 size in reset", AW'(word_size_o), '0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 addr after reset", addr_o, '0);

    // R2 and R5: every page in both widths, load only
    for (int pg = 0; pg < (1 << PW); pg++) begin
      for (int wm = 0; wm < 2; wm++) begin
        do_load(pg, 8'h5A ^ pg, bit'(wm));
        chk(wm ? "R5 word form" : "R2 byte load", addr_o, expect_addr(pg, 8'h5A ^ pg, bit'(wm)));
        chk("R2 size", AW'(word_size_o), AW'(wm));
      end
    end

    // R3, R4, R7: byte sweep over a full window plus wrap
    do_load(10, 8'hF0, 1'b0);
    run_steps(10, 8'hF0, 1'b0, 300, "R3 R4 R7 byte sweep");

    // R5, R6: word sweep with top page bit set (dropped)
    do_load(11, 8'hF8, 1'b1);
    run_steps(11, 8'hF8, 1'b1, 300, "R5 R6 word sweep");
    chk("R6 bit0 low", AW'(addr_o[0]), '0);

    // R4 single step at the window edge
    do_load(3, 8'hFF, 1'b0);
    step_i = 1'b1; @(negedge clk); step_i = 1'b0; @(negedge clk);
    chk("R4 byte wrap to page start", addr_o, expect_addr(3, 0, 1'b0));

    // R10 idle hold
    repeat (5) @(negedge clk);
    chk("R10 hold", addr_o, expect_addr(3, 0, 1'b0));

    // R8 load and step together
    page_i = PW'(6); offset_i = OW'(8'h10); word_mode_i = 1'b0;
    load_i = 1'b1; step_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0; step_i = 1'b0;
    @(negedge clk);
    chk("R8 load beats step", addr_o, expect_addr(6, 8'h10, 1'b0));

    // R9 width toggle without load
    word_mode_i = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 addr unaffected", addr_o, expect_addr(6, 8'h10, 1'b0));
    chk("R9 size unaffected", AW'(word_size_o), '0);

    // R1 reset mid-transfer
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R1 reset clears", addr_o, '0);
    chk("R1 reset clears size", AW'(word_size_o), '0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule